// File: doc/BRIEF.md
# Per-Core Banked Timer Router

This block groups one private down-counting timer per processor core (one to four cores, set by a parameter) behind a single request port. The address space is split into windows of 0x20 bytes each. Window 0 is an alias: it reaches the timer that belongs to the core issuing the request. The core's index travels with the request on a sideband input. Windows 1 to N each reach one fixed timer, core 0 first, so any core can inspect or program any other core's timer.

The router decodes the window and the register offset for each request. It turns the result into a small set of one-cycle strobes and hands them to a datapath that holds the timer instances. The datapath returns registered read data one cycle after the request. Each timer drives its own interrupt line, and the lines are gathered into one vector in core order. An access that cannot be routed produces a one-cycle error pulse in place of data. Core counts outside one to four are rejected when the design is elaborated.

Each timer counts down from a programmed value at a rate set by an 8-bit prescaler. When it expires, it sets a sticky status flag and either reloads or stops.

Top module: `banked_timer_router`

## Requirements
- R1: After reset every timer holds zero in all registers, every `irq` bit is 0, `rspErr` is 0, and reads of any register return 0.
- R2: A read accepted at a clock edge presents its data on `rspData` right after that edge. In every cycle that follows a non-read or a write, `rspData` is 0.
- R3: A request to window 0 (address bits [ADDR_W-1:5] equal to 0) reaches the timer whose index equals `reqCore`, and only that timer.
- R4: A request to window k, for 1 <= k <= NUM_CORES, reaches timer k-1 for any value of `reqCore`.
- R5: The register offsets inside a window are as follows. 0x00 is the reload value. 0x04 is the current count. 0x08 is control, with bit 0 enable, bit 1 auto-reload, bits 15:8 prescale, and all other bits reading 0. 0x0C is status, whose bit 0 is the expiry flag. Offsets 0x10 to 0x1C read 0, ignore writes and raise no error.
- R6: A request is an error when its window is above NUM_CORES, when it targets window 0 with `reqCore` >= NUM_CORES, when `reqBe` is not 4'hF, or when address bits [1:0] are not 0. An error request changes no timer, reads 0, and raises `rspErr` for exactly the one cycle in which its response is presented.
- R7: Writing the reload value also sets the count to the same value. The count reads 0 while the timer is disabled, and reads its live value while enabled.
- R8: When a timer with prescale P is enabled with a count C > 0, its status bit sets at the C*(P+1)-th clock edge after the enabling edge. Its `irq` bit equals its status bit.
- R9: On expiry the count reloads from the reload value if auto-reload is set, and stops at 0 otherwise. Enabling a timer with auto-reload set and a count of 0 first copies the reload value into the count.
- R10: Writing 1 to status bit 0 clears the flag at that edge, and the `irq` bit falls with it. The flag otherwise stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Byte address: window in bits [ADDR_W-1:5], offset in [4:0] |
| reqBe | input | 4 | Byte enables; only 4'hF is a legal access |
| reqCore | input | 2 | Index of the requesting core |
| reqWdata | input | 32 | Write data |
| rspData | output | 32 | Read data, one cycle after the request |
| rspErr | output | 1 | One-cycle error pulse, aligned with the response |
| irq | output | NUM_CORES | Expiry interrupt per timer, bit k for core k |

## Verification
A routing fault, such as a wrong alias target or an off-by-one in the fixed windows, lets a write land in a neighbouring timer. The fault shows at the ports on the next read of either timer, one cycle after that read request. A wrong count or prescale state shows as an `irq` edge one or more cycles away from the C*(P+1) boundary, so the expiry edges are sampled on both sides of that boundary. A failure to detect an error leaves a timer changed where it should not be, or leaves `rspErr` low in the response cycle, and both are seen on the very next response.

// File: rtl/tmr_router_pkg.sv
package tmr_router_pkg;

  localparam int MAX_CORES = 4;
  localparam int OFF_BITS  = 5;
  localparam int DATA_W    = 32;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_AUTO_BIT = 1;
  localparam int CTRL_PRE_LO   = 8;
  localparam int PRE_W         = 8;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STATUS = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [MAX_CORES-1:0] sel;
    logic                 wr;
    logic                 rd;
    logic                 regHit;
    regSel_e              regSel;
    logic                 err;
  } strobe_t;

endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_router_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              acc,
  input  logic              wr,
  input  logic              regHit,
  input  regSel_e           regSel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic [DATA_W-1:0] reloadQ, countQ;
  logic [PRE_W-1:0]  prescQ, prcQ;
  logic              enQ, autoQ, statusQ;

  logic wrReload, wrCount, wrCtrl, wrStatus, progWr, running, tickNow, expire;

  assign wrReload = acc && wr && regHit && (regSel == REG_RELOAD);
  assign wrCount  = acc && wr && regHit && (regSel == REG_COUNT);
  assign wrCtrl   = acc && wr && regHit && (regSel == REG_CTRL);
  assign wrStatus = acc && wr && regHit && (regSel == REG_STATUS);
  assign progWr   = wrReload || wrCount || wrCtrl;
  assign running  = enQ && (countQ != '0);
  assign tickNow  = running && !progWr && (prcQ == prescQ);
  assign expire   = tickNow && (countQ == DATA_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
      countQ  <= '0;
      prescQ  <= '0;
      prcQ    <= '0;
      enQ     <= 1'b0;
      autoQ   <= 1'b0;
    end else if (wrReload) begin
      reloadQ <= wdata;
      countQ  <= wdata;
      prcQ    <= '0;
    end else if (wrCount) begin
      countQ <= wdata;
      prcQ   <= '0;
    end else if (wrCtrl) begin
      enQ    <= wdata[CTRL_EN_BIT];
      autoQ  <= wdata[CTRL_AUTO_BIT];
      prescQ <= wdata[CTRL_PRE_LO +: PRE_W];
      prcQ   <= '0;
      if (!enQ && wdata[CTRL_EN_BIT] && wdata[CTRL_AUTO_BIT] && (countQ == '0))
        countQ <= reloadQ;
    end else if (running) begin
      if (prcQ == prescQ) begin
        prcQ <= '0;
        if (countQ == DATA_W'(1)) countQ <= autoQ ? reloadQ : '0;
        else                      countQ <= countQ - DATA_W'(1);
      end else begin
        prcQ <= prcQ + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        statusQ <= 1'b0;
    else if (expire)                  statusQ <= 1'b1;
    else if (wrStatus && wdata[0])    statusQ <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (regHit) begin
      unique case (regSel)
        REG_RELOAD: rdata = reloadQ;
        REG_COUNT:  rdata = enQ ? countQ : '0;
        REG_CTRL: begin
          rdata[CTRL_EN_BIT]            = enQ;
          rdata[CTRL_AUTO_BIT]          = autoQ;
          rdata[CTRL_PRE_LO +: PRE_W]   = prescQ;
        end
        REG_STATUS: rdata[0] = statusQ;
      endcase
    end
  end

  assign irq = statusQ;

  // R10: flag stays set until a write of 1 to status bit 0
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrStatus && wdata[0])) |=> irq);

  // R7: a stopped timer keeps its count unless software writes it
  p_frozen_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !progWr) |=> $stable(countQ));

  // R8: an expiry raises the interrupt on the next cycle
  p_expire_raises_r8: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> irq);

  // R9: a one-shot expiry leaves the count at zero
  p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !autoQ) |=> (countQ == '0));

endmodule

// File: rtl/route_ctrl.sv
module route_ctrl
  import tmr_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqBe,
  input  logic [1:0]        reqCore,
  output strobe_t           strb
);

  localparam int WIN_W = ADDR_W - OFF_BITS;

  logic [WIN_W-1:0]    win;
  logic [OFF_BITS-1:0] off;
  logic                sizeBad, winMiss, aliasBad, errNow, okNow;
  logic [1:0]          tgt;

  assign win      = reqAddr[ADDR_W-1:OFF_BITS];
  assign off      = reqAddr[OFF_BITS-1:0];
  assign sizeBad  = (reqBe != 4'hF) || (off[1:0] != 2'b00);
  assign winMiss  = int'(win) > NUM_CORES;
  assign aliasBad = (win == '0) && (int'(reqCore) >= NUM_CORES);
  assign errNow   = reqValid && (sizeBad || winMiss || aliasBad);
  assign okNow    = reqValid && !errNow;
  assign tgt      = (win == '0) ? reqCore : 2'(win - WIN_W'(1));

  always_comb begin
    strb        = '0;
    strb.err    = errNow;
    strb.wr     = okNow && reqWrite;
    strb.rd     = okNow && !reqWrite;
    strb.regHit = !off[OFF_BITS-1];
    strb.regSel = regSel_e'(off[3:2]);
    for (int k = 0; k < MAX_CORES; k++) begin
      strb.sel[k] = okNow && (k < NUM_CORES) && (tgt == 2'(k));
    end
  end

  // R3: at most one timer is selected per access
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.sel));

  // R6: an error request selects nothing
  p_err_no_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.err |-> (strb.sel == '0));

  // R3: the alias window follows the requesting core
  p_alias_route_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (win == '0) && !strb.err) |-> strb.sel[reqCore]);

  // R4: fixed windows ignore the requester
  p_direct_route_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (win != '0) && !strb.err) |-> strb.sel[2'(win - WIN_W'(1))]);

endmodule

// File: rtl/route_dp.sv
module route_dp
  import tmr_router_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic [DATA_W-1:0]    rspData,
  output logic                 rspErr,
  output logic [NUM_CORES-1:0] irq
);

  logic [DATA_W-1:0] rdArr [NUM_CORES];
  logic [DATA_W-1:0] rdMux;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_tmr
    tmr_unit u_tmr (
      .clk    (clk),
      .rstN   (rstN),
      .acc    (strb.sel[k]),
      .wr     (strb.wr),
      .regHit (strb.regHit),
      .regSel (strb.regSel),
      .wdata  (reqWdata),
      .rdata  (rdArr[k]),
      .irq    (irq[k])
    );
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (strb.sel[k]) rdMux = rdMux | rdArr[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData <= '0;
      rspErr  <= 1'b0;
    end else begin
      rspData <= strb.rd ? rdMux : '0;
      rspErr  <= strb.err;
    end
  end

  // R6: an error response carries no data
  p_err_zero_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspData == '0));

  // R2: no read accepted means a zero response next cycle
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rd |=> (rspData == '0));

  // R6: the error pulse lasts one cycle unless a new error arrives
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.err |=> !rspErr);

endmodule

// File: rtl/banked_timer_router.sv
module banked_timer_router
  import tmr_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [3:0]           reqBe,
  input  logic [1:0]           reqCore,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic [DATA_W-1:0]    rspData,
  output logic                 rspErr,
  output logic [NUM_CORES-1:0] irq
);

  localparam int MIN_ADDR_W = OFF_BITS + $clog2(NUM_CORES + 1);

  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES || ADDR_W < MIN_ADDR_W) begin : g_badCfg
    initial $fatal(1, "banked_timer_router: core count must be 1..4 and address wide enough");
  end

  strobe_t strb;

  route_ctrl #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqBe    (reqBe),
    .reqCore  (reqCore),
    .strb     (strb)
  );

  route_dp #(.NUM_CORES(NUM_CORES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqWdata (reqWdata),
    .rspData  (rspData),
    .rspErr   (rspErr),
    .irq      (irq)
  );

endmodule

// File: tb/test_banked_timer_router.sv
module test_banked_timer_router;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;
  localparam int AW = 8;
  localparam logic [31:0] CTRL_MASK = 32'h0000_FF03;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0]    reqBe = 4'hF;
  logic [1:0]    reqCore = '0;
  logic [31:0]   reqWdata = '0;
  logic [31:0]   rspData;
  logic          rspErr;
  logic [NC-1:0] irq;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  logic [31:0] mLoad [NC];
  logic [31:0] mCtrl [NC];

  banked_timer_router #(.NUM_CORES(NC), .ADDR_W(AW)) i_banked_timer_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqCore(reqCore), .reqWdata(reqWdata),
    .rspData(rspData), .rspErr(rspErr), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cycles);
      finishRun();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic acc(input int win, input int off, input int core, input bit wr,
                     input logic [31:0] wd, input logic [3:0] be,
                     output logic [31:0] rd, output logic er);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(win * 32 + off);
    reqCore = 2'(core); reqWdata = wd; reqBe = be;
    @(negedge clk);
    rd = rspData; er = rspErr;
    reqValid = 1'b0; reqWrite = 1'b0; reqBe = 4'hF;
  endtask

  task automatic wrReg(input int win, input int core, input int off, input logic [31:0] wd);
    logic [31:0] rd; logic er;
    acc(win, off, core, 1'b1, wd, 4'hF, rd, er);
  endtask

  function automatic logic [31:0] expRead(input int t, input int off);
    case (off)
      0:       return mLoad[t];
      8:       return mCtrl[t];
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    logic [31:0] rd; logic er;
    void'($urandom(32'd20240611));
    for (int t = 0; t < NC; t++) begin mLoad[t] = '0; mCtrl[t] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == '0, "R1", "irq after reset", 32'(irq), 0);
    chk(rspErr == 1'b0, "R1", "rspErr after reset", 32'(rspErr), 0);
    for (int t = 0; t < NC; t++) begin
      for (int o = 0; o < 16; o += 4) begin
        acc(t + 1, o, 0, 1'b0, '0, 4'hF, rd, er);
        chk(rd == 32'h0, "R1", "register after reset", rd, 0);
      end
    end

    // R2 idle cycle after a read returns zero
    wrReg(1, 0, 0, 32'hA5A5_0001); mLoad[0] = 32'hA5A5_0001;
    acc(1, 0, 2, 1'b0, '0, 4'hF, rd, er);
    chk(rd == 32'hA5A5_0001, "R2", "read data one cycle after request", rd, 32'hA5A5_0001);
    @(negedge clk);
    chk(rspData == 32'h0, "R2", "idle cycle data", rspData, 0);

    // R3/R4/R5/R6 randomized accesses to stopped timers
    for (int i = 0; i < 300; i++) begin
      int t, kind, win, core, off, rsel;
      bit wr, isErr;
      logic [31:0] wd;
      logic [3:0] be;
      t = int'($urandom % NC);
      kind = int'($urandom % 10);
      wr = $urandom % 2 == 1;
      rsel = int'($urandom % 5);
      off = (rsel == 4) ? 16 + 4 * int'($urandom % 4) : rsel * 4;
      wd = $urandom;
      if (off == 8) wd = wd & ~32'h1;
      be = 4'hF;
      isErr = 0;
      if (kind < 4) begin win = 0; core = t; end
      else begin win = t + 1; core = int'($urandom % 4); end
      if (kind == 8) begin
        isErr = 1;
        case ($urandom % 4)
          0: begin win = NC + 1 + int'($urandom % (7 - NC)); end
          1: begin win = 0; core = 3; end
          2: begin be = 4'($urandom % 15); end
          default: begin off = off + 1 + int'($urandom % 3); end
        endcase
      end
      acc(win, off, core, wr, wd, be, rd, er);
      chk(er == isErr, "R6", "error pulse", 32'(er), 32'(isErr));
      if (!isErr && wr) begin
        if (off == 0) mLoad[t] = wd;
        if (off == 8) mCtrl[t] = wd & CTRL_MASK;
      end
      if (!wr || isErr) begin
        logic [31:0] e;
        e = (isErr || wr) ? 32'h0 : expRead(t, off);
        chk(rd == e, (kind < 4) ? "R3" : "R4", "routed read", rd, e);
      end
      if ((i % 25) == 0) begin
        @(negedge clk);
        chk(rspErr == 1'b0, "R6", "error pulse width", 32'(rspErr), 0);
      end
      chk(irq == '0, "R5", "no interrupt from stopped timers", 32'(irq), 0);
    end
    // sweep every register of every timer through both window kinds
    for (int t = 0; t < NC; t++) begin
      for (int o = 0; o < 32; o += 4) begin
        acc(t + 1, o, 3, 1'b0, '0, 4'hF, rd, er);
        chk(rd == expRead(t, o), "R4", "direct sweep", rd, expRead(t, o));
        acc(0, o, t, 1'b0, '0, 4'hF, rd, er);
        chk(rd == expRead(t, o), "R3", "alias sweep", rd, expRead(t, o));
      end
    end

    // R7 count reads zero while disabled, reload also loads count
    wrReg(2, 2, 0, 32'd5);
    acc(2, 4, 0, 1'b0, '0, 4'hF, rd, er);
    chk(rd == 32'h0, "R7", "count while disabled", rd, 0);

    // R8 one-shot expiry of timer 1, prescale 0, count 5
    wrReg(2, 0, 8, 32'h0000_0001);
    repeat (4) @(negedge clk);
    chk(irq == 3'b000, "R8", "irq one edge before expiry", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 3'b010, "R8", "irq at expiry", 32'(irq), 32'b010);
    acc(0, 4, 1, 1'b0, '0, 4'hF, rd, er);
    chk(rd == 32'h0, "R9", "one-shot count stopped", rd, 0);
    acc(2, 12, 2, 1'b0, '0, 4'hF, rd, er);
    chk(rd == 32'h1, "R5", "status bit after expiry", rd, 1);
    repeat (3) @(negedge clk);
    chk(irq == 3'b010, "R10", "flag stays set", 32'(irq), 32'b010);
    wrReg(0, 1, 12, 32'h1);
    chk(irq == 3'b000, "R10", "irq after clear", 32'(irq), 0);
    wrReg(2, 0, 8, 32'h0);

    // R9 auto-reload on timer 0, prescale 1, count 3 -> period 6 edges
    wrReg(1, 1, 0, 32'd3);
    wrReg(1, 1, 8, 32'h0000_0103);
    repeat (5) @(negedge clk);
    chk(irq == 3'b000, "R8", "prescaled irq before expiry", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 3'b001, "R8", "prescaled irq at expiry", 32'(irq), 1);
    wrReg(0, 0, 12, 32'h1);
    chk(irq == 3'b000, "R10", "clear while running", 32'(irq), 0);
    repeat (4) @(negedge clk);
    chk(irq == 3'b000, "R9", "before second expiry", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 3'b001, "R9", "second expiry after reload", 32'(irq), 1);
    acc(1, 4, 2, 1'b0, '0, 4'hF, rd, er);
    chk(rd == 32'd3, "R7", "live count after reload", rd, 3);
    wrReg(1, 0, 8, 32'h0);
    wrReg(1, 0, 12, 32'h1);

    // R9 enabling with zero count copies the reload value (timer 2)
    wrReg(3, 0, 0, 32'd2);
    wrReg(3, 0, 4, 32'd0);
    wrReg(3, 0, 8, 32'h0000_0003);
    @(negedge clk);
    chk(irq == 3'b000, "R9", "copied count not yet expired", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 3'b100, "R9", "copied count expiry", 32'(irq), 32'b100);

    // R6 error write leaves timer 2 untouched
    acc(0, 0, 3, 1'b1, 32'hDEAD_BEEF, 4'hF, rd, er);
    chk(er == 1'b1, "R6", "alias from unknown core", 32'(er), 1);
    acc(3, 0, 0, 1'b0, '0, 4'hF, rd, er);
    chk(rd == 32'd2, "R6", "reload unchanged by error write", rd, 2);

    finishRun();
  end

endmodule